// File: doc/BRIEF.md
# NAND Sector Single-Bit ECC Engine

This engine builds a Hamming-style check code over one 512-byte NAND sector while the bytes stream through it, and then either hands out that code for storage or compares it against a code read back from the flash. Bytes enter through a valid/ready port. A start pulse clears the running parity and selects the direction. In generate mode the engine emits three code bytes once the sector ends. In check mode it then accepts the three stored code bytes and reports one of four outcomes.

The running parity is twelve pairs of bit parities, one pair per address bit of the 4096 data bits. It is packed into a 24-bit word and inverted, so an erased sector and its erased code bytes agree. When a single data bit has flipped, the check result gives the byte offset and a one-hot mask of the bit to invert. Host logic applies the correction to its own buffer. The engine never touches the data.

Top module: `nand_ecc_core`

## Requirements
- R1: After reset, in_ready, out_valid and res_valid are low until a start pulse arrives, and bytes offered while in_ready is low are not taken.
- R2: A start pulse clears the parity and raises in_ready from the next cycle. in_ready then stays high, with any pattern of in_valid gaps, until 512 data bytes are accepted. In check mode it stays high for 3 more accepted bytes.
- R3: In generate mode, out_valid is high for exactly 3 consecutive cycles, starting the cycle after the 512th byte is accepted. out_byte carries code bits 7:0, then 15:8, then 23:16. The code is the bitwise inverse of {P1, P0}. For each bit A of a data bit's 12-bit address (byte offset × 8 + bit number, bit 0 = LSB), P1[k] is the XOR of all data bits whose address bit k is 1, and P0[k] is the XOR of those whose address bit k is 0.
- R4: A sector of all 0xFF bytes yields the code bytes FF, FF, FF.
- R5: In check mode, the three stored bytes are taken LSB first. res_valid is a one-cycle pulse in the cycle after the third is accepted.
- R6: The difference is computed code XOR stored code. When it is zero, res_status = 0 (clean) and res_offset and res_mask are 0.
- R7: When the low 12 difference bits XOR the high 12 bits equal 0xFFF, res_status = 1 (data fixed). In that case res_offset = difference bits 23:15 and res_mask = 1 << difference bits 14:12.
- R8: A difference with exactly one bit set gives res_status = 2 (code byte error only) with res_offset and res_mask zero.
- R9: Any other nonzero difference, such as two flipped data bits, gives res_status = 3 (uncorrectable) with res_mask zero.
- R10: A start pulse during a transfer abandons it and begins a fresh sector. A byte offered in the same cycle as start is dropped.
- R11: in_valid pulses while the engine is idle leave the next sector's code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sector; clears the parity |
| check_mode | input | 1 | Sampled with start: 1 = check, 0 = generate |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Engine takes a byte this cycle |
| in_data | input | 8 | Sector data byte, or stored code byte |
| out_valid | output | 1 | out_byte holds a code byte |
| out_byte | output | 8 | Generated code byte, LSB byte first |
| res_valid | output | 1 | Check result pulse |
| res_status | output | 2 | 0 clean, 1 data fixed, 2 code-only error, 3 uncorrectable |
| res_offset | output | 9 | Byte offset of the bit to flip |
| res_mask | output | 8 | One-hot mask of the bit to flip |

## Verification
An incrementing pattern and an all-0xFF sector are run through generate mode. The first tests the packing of every parity pair. The second shows that the inversion makes an erased sector agree with its erased code. Check runs then use the same data with the stored code left intact, with single data bits flipped at byte 0, byte 300 and byte 511, with one stored code bit flipped, and with two data bits flipped. Each of these drives the decoder down a different branch. A stalled stream with valid gaps, a restart in the middle of a sector, and bytes offered while idle show that the byte counter and the parity take only bytes that were handshaken.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_FIXED     = 2'd1,
        ST_CODE_ONLY = 2'd2,
        ST_BAD       = 2'd3
    } ecc_status_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_DATA   = 3'd1,
        PH_CODE   = 3'd2,
        PH_EMIT   = 3'd3,
        PH_RESULT = 3'd4
    } phase_e;

endpackage

// File: rtl/nand_ecc_accum.sv
// Running parity pairs: for every address bit of a data bit, one parity over
// the bits where that address bit is set and one over the bits where it is clear.
module nand_ecc_accum #(
    parameter int ADDR_W = 9,
    parameter int RAW_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [7:0]        byte_in,
    output logic [RAW_W-1:0]  raw
);
    localparam int HALF     = ADDR_W + 3;
    localparam int HIGH_POS = RAW_W / 2;

    typedef struct packed {
        logic [HALF-1:0] set_par;
        logic [HALF-1:0] clr_par;
    } par_t;

    par_t par_d, par_q;
    logic [2:0] col_set, col_clr;
    logic       row_par;

    // Column parities: bit-number bit k set / clear inside one byte.
    always_comb begin
        row_par = ^byte_in;
        for (int k = 0; k < 3; k++) begin
            col_set[k] = 1'b0;
            col_clr[k] = 1'b0;
            for (int b = 0; b < 8; b++) begin
                if (((b >> k) & 1) == 1) col_set[k] = col_set[k] ^ byte_in[b];
                else                     col_clr[k] = col_clr[k] ^ byte_in[b];
            end
        end
    end

    always_comb begin
        par_d = par_q;
        if (clear) begin
            par_d = '0;
        end else if (en) begin
            par_d.set_par = par_q.set_par ^ {byte_addr & {ADDR_W{row_par}}, col_set};
            par_d.clr_par = par_q.clr_par ^ {~byte_addr & {ADDR_W{row_par}}, col_clr};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    // Raw word: clear-parities low, set-parities from the middle up, rest zero.
    always_comb begin
        raw = '0;
        raw[HALF-1:0]         = par_q.clr_par;
        raw[HIGH_POS +: HALF] = par_q.set_par;
    end

endmodule

// File: rtl/nand_ecc_eval.sv
// Syndrome decode of computed versus stored code.
module nand_ecc_eval
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int SECTOR_BYTES = 512
) (
    input  logic [2*(ADDR_W+3)-1:0] computed,
    input  logic [2*(ADDR_W+3)-1:0] stored,
    output ecc_status_e             status,
    output logic [ADDR_W-1:0]       offset,
    output logic [7:0]              mask
);
    localparam int HALF   = ADDR_W + 3;
    localparam int CODE_W = 2 * HALF;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SECTOR_BYTES);

    logic [CODE_W-1:0] diff;
    logic [HALF-1:0]   lo, hi;

    always_comb begin
        diff   = computed ^ stored;
        lo     = diff[HALF-1:0];
        hi     = diff[CODE_W-1:HALF];
        status = ST_CLEAN;
        offset = '0;
        mask   = '0;
        if (diff != '0) begin
            if ((lo ^ hi) == {HALF{1'b1}}) begin
                if ({1'b0, hi[HALF-1:3]} < LIMIT) begin
                    status = ST_FIXED;
                    offset = hi[HALF-1:3];
                    mask   = 8'd1 << hi[2:0];
                end else begin
                    status = ST_BAD;
                end
            end else if ($onehot(diff)) begin
                status = ST_CODE_ONLY;
            end else begin
                status = ST_BAD;
            end
        end
    end

endmodule

// File: rtl/nand_ecc_core.sv
module nand_ecc_core
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            check_mode,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [7:0]                      in_data,
    output logic                            out_valid,
    output logic [7:0]                      out_byte,
    output logic                            res_valid,
    output logic [1:0]                      res_status,
    output logic [$clog2(SECTOR_BYTES)-1:0] res_offset,
    output logic [7:0]                      res_mask
);
    localparam int ADDR_W     = $clog2(SECTOR_BYTES);
    localparam int HALF       = ADDR_W + 3;
    localparam int CODE_W     = 2 * HALF;
    localparam int CODE_BYTES = CODE_W / 8;
    localparam int RAW_W      = 32;
    localparam int HIGH_POS   = RAW_W / 2;
    localparam logic [ADDR_W-1:0] LAST_BYTE = ADDR_W'(SECTOR_BYTES - 1);
    localparam logic [1:0]        LAST_CODE = 2'(CODE_BYTES - 1);

    typedef struct packed {
        phase_e            ph;
        logic              chk;
        logic [ADDR_W-1:0] cnt;
        logic [1:0]        idx;
        logic [CODE_W-1:0] stored;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              take;
    logic [RAW_W-1:0]  raw;
    logic [CODE_W-1:0] code;
    ecc_status_e       ev_status;
    logic [ADDR_W-1:0] ev_offset;
    logic [7:0]        ev_mask;

    assign in_ready = (ctl_q.ph == PH_DATA) || (ctl_q.ph == PH_CODE);
    assign take     = in_valid && in_ready && !start;

    always_comb begin
        ctl_d = ctl_q;
        if (start) begin
            ctl_d.ph     = PH_DATA;
            ctl_d.chk    = check_mode;
            ctl_d.cnt    = '0;
            ctl_d.idx    = '0;
            ctl_d.stored = '0;
        end else begin
            case (ctl_q.ph)
                PH_DATA: if (take) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_BYTE) begin
                        ctl_d.ph  = ctl_q.chk ? PH_CODE : PH_EMIT;
                        ctl_d.idx = '0;
                    end
                end
                PH_CODE: if (take) begin
                    ctl_d.stored[8*ctl_q.idx +: 8] = in_data;
                    ctl_d.idx = ctl_q.idx + 2'd1;
                    if (ctl_q.idx == LAST_CODE) ctl_d.ph = PH_RESULT;
                end
                PH_EMIT: begin
                    ctl_d.idx = ctl_q.idx + 2'd1;
                    if (ctl_q.idx == LAST_CODE) ctl_d.ph = PH_IDLE;
                end
                default: ctl_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.ph  <= PH_IDLE;
        end else begin
            ctl_q     <= ctl_d;
        end
    end

    nand_ecc_accum #(
        .ADDR_W (ADDR_W),
        .RAW_W  (RAW_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .en        (take && (ctl_q.ph == PH_DATA)),
        .byte_addr (ctl_q.cnt),
        .byte_in   (in_data),
        .raw       (raw)
    );

    // Squeeze out the reserved gaps of the raw word, then invert.
    assign code = ~{raw[HIGH_POS +: HALF], raw[HALF-1:0]};

    nand_ecc_eval #(
        .ADDR_W       (ADDR_W),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_eval (
        .computed (code),
        .stored   (ctl_q.stored),
        .status   (ev_status),
        .offset   (ev_offset),
        .mask     (ev_mask)
    );

    assign out_valid  = (ctl_q.ph == PH_EMIT);
    assign out_byte   = out_valid ? code[8*ctl_q.idx +: 8] : 8'h00;
    assign res_valid  = (ctl_q.ph == PH_RESULT);
    assign res_status = res_valid ? ev_status : ST_CLEAN;
    assign res_offset = res_valid ? ev_offset : '0;
    assign res_mask   = res_valid ? ev_mask   : '0;

endmodule

// File: rtl/nand_ecc_core_chk.sv
module nand_ecc_core_chk #(
    parameter int OFF_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_ready,
    input logic             out_valid,
    input logic             res_valid,
    input logic [1:0]       res_status,
    input logic [OFF_W-1:0] res_offset,
    input logic [7:0]       res_mask
);
    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> in_ready); // R2
    AST_EMIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!in_ready && !res_valid)); // R3
    AST_EMIT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_valid) && !start) |=> out_valid); // R3
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R5
    AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'd0) |-> (res_mask == 8'd0 && res_offset == '0)); // R6
    AST_FIX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'd1) |-> $onehot(res_mask)); // R7
    AST_CODE_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'd2) |-> (res_mask == 8'd0)); // R8
    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'd3) |-> (res_mask == 8'd0)); // R9
endmodule

bind nand_ecc_core nand_ecc_core_chk #(.OFF_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .res_valid  (res_valid),
    .res_status (res_status),
    .res_offset (res_offset),
    .res_mask   (res_mask)
);

// File: tb/nand_ecc_core_bench.sv
module nand_ecc_core_bench;
    localparam int SECTOR = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       start = 1'b0, check_mode = 1'b0, in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, res_valid;
    logic [7:0] out_byte, res_mask;
    logic [1:0] res_status;
    logic [8:0] res_offset;

    nand_ecc_core u_nand_ecc_core (
        .clk(clk), .rst_n(rst_n), .start(start), .check_mode(check_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_byte(out_byte), .res_valid(res_valid),
        .res_status(res_status), .res_offset(res_offset), .res_mask(res_mask)
    );

    int n_chk = 0, n_fail = 0;
    string tag = "R1";

    // Reference model state
    logic [7:0]  pat [SECTOR];
    logic [7:0]  sect [SECTOR];
    logic [7:0]  stored [3];
    logic [23:0] exp_code;
    int ph = 0, cnt = 0, idx = 0;
    bit md = 1'b0;

    function automatic logic [23:0] code_of(input logic [7:0] a [SECTOR]);
        int p1 = 0, p0 = 0;
        logic [23:0] r;
        for (int j = 0; j < SECTOR; j++)
            for (int b = 0; b < 8; b++)
                if (a[j][b]) begin
                    int adr = j * 8 + b;
                    for (int k = 0; k < 12; k++)
                        if (((adr >> k) & 1) == 1) p1 = p1 ^ (1 << k);
                        else                       p0 = p0 ^ (1 << k);
                end
        r = 24'((p1 << 12) | p0);
        return ~r;
    endfunction

    task automatic check(input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] d, input bit s);
        int diff, hi, lo, es, eo, em;
        bit acc;
        @(negedge clk);
        start = s; in_valid = v; in_data = d;
        check("in_ready", int'(in_ready), int'(ph == 1 || ph == 2));
        check("out_valid", int'(out_valid), int'(ph == 3));
        check("res_valid", int'(res_valid), int'(ph == 4));
        if (ph == 3) check("out_byte", int'(out_byte), int'(exp_code[8*idx +: 8]));
        if (ph == 4) begin
            diff = int'(exp_code ^ {stored[2], stored[1], stored[0]});
            hi = diff >> 12; lo = diff & 'hFFF;
            es = 0; eo = 0; em = 0;
            if (diff != 0) begin
                if ((hi ^ lo) == 'hFFF) begin
                    if ((hi >> 3) < SECTOR) begin es = 1; eo = hi >> 3; em = 1 << (hi & 7); end
                    else es = 3;
                end else if ($countones(diff) == 1) es = 2;
                else es = 3;
            end
            check("res_status", int'(res_status), es);
            check("res_offset", int'(res_offset), eo);
            check("res_mask", int'(res_mask), em);
        end
        acc = v && (ph == 1 || ph == 2);
        @(posedge clk);
        if (s) begin
            ph = 1; cnt = 0; md = check_mode;
        end else begin
            case (ph)
                1: if (acc) begin
                    sect[cnt] = d; cnt++;
                    if (cnt == SECTOR) begin ph = md ? 2 : 3; idx = 0; exp_code = code_of(sect); end
                end
                2: if (acc) begin
                    stored[idx] = d; idx++;
                    if (idx == 3) ph = 4;
                end
                3: begin idx++; if (idx == 3) ph = 0; end
                4: ph = 0;
                default: ph = 0;
            endcase
        end
    endtask

    task automatic run_sector(input bit cm, input int gap, input logic [23:0] st);
        check_mode = cm;
        step(1'b0, 8'h00, 1'b1);
        for (int j = 0; j < SECTOR; j++) begin
            if (gap != 0 && (j % gap) == 0) step(1'b0, 8'h00, 1'b0);
            step(1'b1, pat[j], 1'b0);
        end
        if (cm) for (int i = 0; i < 3; i++) step(1'b1, st[8*i +: 8], 1'b0);
        while (ph != 0) step(1'b0, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: got hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [23:0] good;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        tag = "R1";
        for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b0);

        tag = "R11_idle_bytes";
        for (int i = 0; i < 4; i++) step(1'b1, 8'h5A, 1'b0);

        tag = "R3_generate_incr";
        for (int j = 0; j < SECTOR; j++) pat[j] = 8'(j * 7 + 3);
        run_sector(1'b0, 0, 24'h0);
        check("R11 code unaffected by idle bytes", int'(exp_code), int'(code_of(pat)));

        tag = "R4_erased_generate";
        for (int j = 0; j < SECTOR; j++) pat[j] = 8'hFF;
        run_sector(1'b0, 0, 24'h0);
        check("erased code", int'(exp_code), 'hFFFFFF);

        tag = "R6_erased_check";
        run_sector(1'b1, 0, 24'hFFFFFF);

        tag = "R2_stalled_clean_check";
        for (int j = 0; j < SECTOR; j++) pat[j] = 8'((j * 13) ^ (j >> 3));
        good = code_of(pat);
        run_sector(1'b1, 5, good);

        tag = "R7_flip_byte300_bit5";
        pat[300] = pat[300] ^ 8'h20;
        run_sector(1'b1, 0, good);
        pat[300] = pat[300] ^ 8'h20;

        tag = "R7_flip_byte0_bit0";
        pat[0] = pat[0] ^ 8'h01;
        run_sector(1'b1, 0, good);
        pat[0] = pat[0] ^ 8'h01;

        tag = "R7_flip_byte511_bit7";
        pat[511] = pat[511] ^ 8'h80;
        run_sector(1'b1, 0, good);
        pat[511] = pat[511] ^ 8'h80;

        tag = "R8_code_bit_flip";
        run_sector(1'b1, 0, good ^ 24'h001000);

        tag = "R9_two_data_flips";
        pat[10] = pat[10] ^ 8'h04;
        pat[77] = pat[77] ^ 8'h40;
        run_sector(1'b1, 0, good);
        pat[10] = pat[10] ^ 8'h04;
        pat[77] = pat[77] ^ 8'h40;

        tag = "R10_restart";
        check_mode = 1'b0;
        step(1'b1, 8'h3C, 1'b1);
        for (int j = 0; j < 100; j++) step(1'b1, 8'(j ^ 8'hC3), 1'b0);
        check_mode = 1'b1;
        step(1'b1, 8'hE7, 1'b1);
        for (int j = 0; j < SECTOR; j++) step(1'b1, pat[j], 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, good[8*i +: 8], 1'b0);
        while (ph != 0) step(1'b0, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b0);
        check("R10 restarted code", int'(exp_code), int'(good));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule